// File: doc/BRIEF.md
# Paged Program Counter With Return Stack

This block keeps the fetch address of a small 8-bit controller and a two-slot return stack. In every cycle where the core advances (`step_en` high), it works out the next fetch address from the flow class that the decoder has already found. That address can be the next word, the word after next when the decoder asks for a skip, a full 10-bit target taken from the instruction, a short target whose top bit comes from the status page bit, a value popped from the stack, or an ALU byte written to the PC register. Calls push the address that follows the call. Returns pop the stack back into the PC.

Short flow keeps to one half of the 1024-word space. The page bit picks the lower half (000–1FF) when it is 0 and the upper half (200–3FF) when it is 1. Short calls and PC writes can only reach the first 256 words of the chosen half, because the block forces address bit 8 to zero for them. The stack is a two-slot ring. It never refuses a push, and a pop on an empty stack is harmless.

The asynchronous active-low reset passes through a two-stage synchronizer, so the block leaves reset on a clock edge. From reset, fetch starts at the last word of program memory.

Top module: `pcs_pc_unit`

## Requirements
- R1: Two clock edges after `rst_n` rises, `fetch_addr` is 0x3FF and no step has yet been taken. A return issued then loads 0x3FF, because every stack slot resets to all ones.
- R2: The flow class `flow_op` is encoded as follows: 0 sequential, 1 long jump, 2 long call, 3 short jump, 4 short call, 5 return, 6 PC write, 7 behaves as sequential. The block acts on a class only on an edge where `step_en` is 1. When `step_en` is 0, neither `fetch_addr` nor the stack changes.
- R3: A sequential step loads `fetch_addr + 1` modulo 1024, so 0x3FF is followed by 0x000.
- R4: A sequential step with `skip_req` = 1 loads `fetch_addr + 2` modulo 1024. `skip_req` has no effect on any other class and leaves the stack untouched.
- R5: A long jump and a long call load all ten bits of `addr_field`.
- R6: A short jump loads `{page_sel, addr_field[8:0]}`.
- R7: A short call loads `{page_sel, 1'b0, addr_field[7:0]}` and ignores `addr_field[9:8]`.
- R8: A PC write loads `{page_sel, 1'b0, alu_result}` and ignores `addr_field`.
- R9: Both call classes push `fetch_addr + 1` (modulo 1024), taken before the step. A return loads the most recently pushed entry that has not yet been popped, so entries come back last-in first-out.
- R10: A push when both slots are occupied overwrites the older entry. The two returns that follow yield the newest entry and then the middle one.
- R11: A return on an empty stack loads the entry returned by the latest pop (0x3FF if there has been none since reset) and leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside |
| step_en | input | 1 | Advance enable: PC and stack update only when high |
| flow_op | input | 3 | Decoded flow class (encoding in R2) |
| addr_field | input | 10 | Address field of the instruction |
| alu_result | input | 8 | ALU byte for PC writes |
| page_sel | input | 1 | Status page bit: 0 lower half, 1 upper half |
| skip_req | input | 1 | Skip the next word on a sequential step |
| fetch_addr | output | 10 | Current fetch address |

## Verification
Most faults in the address mux show at `fetch_addr` on the edge after the faulty step: a wrong bit source, a missing forced zero on bit 8 or a wrong increment shows up one edge later. Stack faults stay hidden until a later return. A pointer that moves wrongly on overflow, a count that does not saturate, or a skip that disturbs the stack appears only when the affected entry is popped, which can be several steps after the cause. The bench therefore chains calls, overflow and underflow pops, and compares every return target against values computed by hand.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    FL_SEQ   = 3'd0,
    FL_LJMP  = 3'd1,
    FL_LCALL = 3'd2,
    FL_SJMP  = 3'd3,
    FL_SCALL = 3'd4,
    FL_RET   = 3'd5,
    FL_PCWR  = 3'd6,
    FL_SPARE = 3'd7
  } flow_e;

endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
  import pcs_pkg::*;
#(
  parameter int PC_W    = 10,
  parameter int SHORT_W = 8
) (
  input  flow_e             op,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   addr,
  input  logic [SHORT_W-1:0] alu,
  input  logic              page,
  input  logic              skip,
  input  logic [PC_W-1:0]   pop_val,
  output logic [PC_W-1:0]   next_pc,
  output logic [PC_W-1:0]   push_val,
  output logic              push_req,
  output logic              pop_req
);

  localparam int GAP_W = PC_W - 1 - SHORT_W;
  localparam logic [PC_W-1:0] INC1 = PC_W'(1);
  localparam logic [PC_W-1:0] INC2 = PC_W'(2);

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] short_jmp_pc;
  logic [PC_W-1:0] short_call_pc;
  logic [PC_W-1:0] write_pc;

  assign push_val      = pc + INC1;
  assign seq_pc        = pc + (skip ? INC2 : INC1);
  assign short_jmp_pc  = {page, addr[PC_W-2:0]};
  assign short_call_pc = {page, {GAP_W{1'b0}}, addr[SHORT_W-1:0]};
  assign write_pc      = {page, {GAP_W{1'b0}}, alu};

  always_comb begin
    next_pc  = seq_pc;
    push_req = 1'b0;
    pop_req  = 1'b0;
    unique case (op)
      FL_LJMP:  next_pc = addr;
      FL_LCALL: begin
        next_pc  = addr;
        push_req = 1'b1;
      end
      FL_SJMP:  next_pc = short_jmp_pc;
      FL_SCALL: begin
        next_pc  = short_call_pc;
        push_req = 1'b1;
      end
      FL_RET: begin
        next_pc = pop_val;
        pop_req = 1'b1;
      end
      FL_PCWR:  next_pc = write_pc;
      default:  next_pc = seq_pc;
    endcase
  end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] pop_val
);

  localparam int DEPTH = 2;
  localparam int PTR_W = 1;
  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_empty;

  assign is_empty = (cnt_q == '0);

  // newest entry sits just behind the pointer; an empty pop rereads the slot last vacated
  assign pop_val = is_empty ? slot_q[ptr_q] : slot_q[~ptr_q];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_we
    assign slot_we[gi] = en && push && (ptr_q == PTR_W'(gi));
  end

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (en && push) begin
      ptr_d = ~ptr_q;
      cnt_d = (cnt_q == FULL) ? FULL : cnt_q + CNT_W'(1);
    end else if (en && pop && !is_empty) begin
      ptr_d = ~ptr_q;
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (slot_we[i]) slot_q[i] <= push_val;
      end
    end
  end

  a_r10_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  a_r9_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    (en && push) |=> (pop_val == $past(push_val)));

  a_r11_empty_pop_still: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pop && !push && is_empty) |=> ($stable(pop_val) && is_empty));

  a_r2_idle_stack: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(ptr_q) && $stable(cnt_q) && $stable(pop_val)));

endmodule

// File: rtl/pcs_pc_unit.sv
module pcs_pc_unit
  import pcs_pkg::*;
#(
  parameter int PC_W    = 10,
  parameter int SHORT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic [2:0]         flow_op,
  input  logic [PC_W-1:0]    addr_field,
  input  logic [SHORT_W-1:0] alu_result,
  input  logic               page_sel,
  input  logic               skip_req,
  output logic [PC_W-1:0]    fetch_addr
);

  logic            rst_n_int;
  flow_e           op;
  logic [PC_W-1:0] pc_q, pc_d, next_pc;
  logic [PC_W-1:0] push_val, pop_val;
  logic            push_req, pop_req;

  assign op = flow_e'(flow_op);

  pcs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pcs_next_addr #(.PC_W(PC_W), .SHORT_W(SHORT_W)) u_next (
    .op       (op),
    .pc       (pc_q),
    .addr     (addr_field),
    .alu      (alu_result),
    .page     (page_sel),
    .skip     (skip_req),
    .pop_val  (pop_val),
    .next_pc  (next_pc),
    .push_val (push_val),
    .push_req (push_req),
    .pop_req  (pop_req)
  );

  pcs_ret_stack #(.W(PC_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .en       (step_en),
    .push     (push_req),
    .pop      (pop_req),
    .push_val (push_val),
    .pop_val  (pop_val)
  );

  always_comb begin
    pc_d = pc_q;
    if (step_en) pc_d = next_pc;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) pc_q <= '1;
    else            pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;

  a_r2_hold_pc: assert property (@(posedge clk) disable iff (!rst_n_int)
    !step_en |=> $stable(fetch_addr));

  a_r3_seq_inc: assert property (@(posedge clk) disable iff (!rst_n_int)
    (step_en && (op == FL_SEQ || op == FL_SPARE) && !skip_req)
      |=> (fetch_addr == PC_W'($past(fetch_addr) + PC_W'(1))));

  a_r4_skip_inc: assert property (@(posedge clk) disable iff (!rst_n_int)
    (step_en && op == FL_SEQ && skip_req)
      |=> (fetch_addr == PC_W'($past(fetch_addr) + PC_W'(2))));

  a_r5_long_target: assert property (@(posedge clk) disable iff (!rst_n_int)
    (step_en && (op == FL_LJMP || op == FL_LCALL)) |=> (fetch_addr == $past(addr_field)));

  a_r7_short_call_page: assert property (@(posedge clk) disable iff (!rst_n_int)
    (step_en && op == FL_SCALL)
      |=> (!fetch_addr[PC_W-2] && fetch_addr[PC_W-1] == $past(page_sel)));

  a_r8_pc_write: assert property (@(posedge clk) disable iff (!rst_n_int)
    (step_en && op == FL_PCWR)
      |=> (fetch_addr[SHORT_W-1:0] == $past(alu_result) && !fetch_addr[PC_W-2]));

endmodule

// File: tb/pcs_pc_unit_tb.sv
module pcs_pc_unit_tb;

  logic       clk;
  logic       rst_n;
  logic       step_en;
  logic [2:0] flow_op;
  logic [9:0] addr_field;
  logic [7:0] alu_result;
  logic       page_sel;
  logic       skip_req;
  logic [9:0] fetch_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [2:0] OP_SEQ = 3'd0, OP_LJMP = 3'd1, OP_LCALL = 3'd2,
                         OP_SJMP = 3'd3, OP_SCALL = 3'd4, OP_RET = 3'd5,
                         OP_PCWR = 3'd6, OP_SPARE = 3'd7;

  pcs_pc_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .flow_op    (flow_op),
    .addr_field (addr_field),
    .alu_result (alu_result),
    .page_sel   (page_sel),
    .skip_req   (skip_req),
    .fetch_addr (fetch_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: fetch_addr=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; the result is read on the next falling edge
  task automatic step(input logic [2:0] op, input logic [9:0] a, input logic [7:0] alu,
                      input logic pg, input logic sk);
    @(negedge clk);
    flow_op = op; addr_field = a; alu_result = alu; page_sel = pg; skip_req = sk;
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step_en = 1'b0; flow_op = OP_SEQ; addr_field = '0; alu_result = '0;
    page_sel = 1'b0; skip_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset vector", fetch_addr, 10'h3FF);
    step(OP_RET, 10'h000, 8'h00, 1'b0, 1'b0);
    check("R1 pop after reset", fetch_addr, 10'h3FF);
  endtask

  task automatic t_hold();
    do_reset();
    @(negedge clk);
    flow_op = OP_LJMP; addr_field = 10'h155; step_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 hold pc", fetch_addr, 10'h3FF);
    step(OP_LCALL, 10'h040, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    flow_op = OP_RET; step_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 hold on idle return", fetch_addr, 10'h040);
    step(OP_RET, 10'h000, 8'h00, 1'b0, 1'b0);
    check("R2 stack kept", fetch_addr, 10'h000);
  endtask

  task automatic t_seq();
    do_reset();
    step(OP_SEQ, 10'h123, 8'h00, 1'b1, 1'b0);
    check("R3 wrap", fetch_addr, 10'h000);
    step(OP_SPARE, 10'h000, 8'h00, 1'b0, 1'b0);
    check("R3 spare code", fetch_addr, 10'h001);
  endtask

  task automatic t_skip();
    do_reset();
    step(OP_LJMP, 10'h0F0, 8'h00, 1'b0, 1'b0);
    step(OP_LCALL, 10'h3FE, 8'h00, 1'b0, 1'b0);
    step(OP_SEQ, 10'h000, 8'h00, 1'b0, 1'b1);
    check("R4 skip wrap", fetch_addr, 10'h000);
    step(OP_SEQ, 10'h000, 8'h00, 1'b0, 1'b1);
    check("R4 skip", fetch_addr, 10'h002);
    step(OP_LJMP, 10'h100, 8'h00, 1'b0, 1'b1);
    check("R4 skip ignored on jump", fetch_addr, 10'h100);
    step(OP_RET, 10'h000, 8'h00, 1'b0, 1'b1);
    check("R4 stack untouched", fetch_addr, 10'h0F1);
  endtask

  task automatic t_long();
    do_reset();
    step(OP_LJMP, 10'h2A5, 8'h00, 1'b0, 1'b0);
    check("R5 long jump", fetch_addr, 10'h2A5);
    step(OP_LCALL, 10'h155, 8'h00, 1'b1, 1'b0);
    check("R5 long call", fetch_addr, 10'h155);
    step(OP_RET, 10'h000, 8'h00, 1'b0, 1'b0);
    check("R9 return", fetch_addr, 10'h2A6);
  endtask

  task automatic t_short_jmp();
    do_reset();
    step(OP_SJMP, 10'h0AB, 8'h00, 1'b1, 1'b0);
    check("R6 short jump upper", fetch_addr, 10'h2AB);
    step(OP_SJMP, 10'h3FF, 8'h00, 1'b0, 1'b0);
    check("R6 short jump lower", fetch_addr, 10'h1FF);
  endtask

  task automatic t_short_call();
    do_reset();
    step(OP_LJMP, 10'h1FF, 8'h00, 1'b0, 1'b0);
    step(OP_SCALL, 10'h3CD, 8'h00, 1'b1, 1'b0);
    check("R7 short call", fetch_addr, 10'h2CD);
    step(OP_SCALL, 10'h112, 8'h00, 1'b0, 1'b0);
    check("R7 short call lower", fetch_addr, 10'h012);
    step(OP_RET, 10'h000, 8'h00, 1'b1, 1'b0);
    check("R9 lifo first", fetch_addr, 10'h2CE);
    step(OP_RET, 10'h000, 8'h00, 1'b1, 1'b0);
    check("R9 lifo second", fetch_addr, 10'h200);
  endtask

  task automatic t_pcwr();
    do_reset();
    step(OP_PCWR, 10'h3FF, 8'hEE, 1'b0, 1'b0);
    check("R8 pc write lower", fetch_addr, 10'h0EE);
    step(OP_PCWR, 10'h000, 8'h11, 1'b1, 1'b0);
    check("R8 pc write upper", fetch_addr, 10'h211);
  endtask

  task automatic t_overflow();
    do_reset();
    step(OP_LJMP, 10'h010, 8'h00, 1'b0, 1'b0);
    step(OP_LCALL, 10'h100, 8'h00, 1'b0, 1'b0);
    step(OP_LCALL, 10'h200, 8'h00, 1'b0, 1'b0);
    step(OP_LCALL, 10'h300, 8'h00, 1'b0, 1'b0);
    step(OP_RET, 10'h000, 8'h00, 1'b0, 1'b0);
    check("R10 newest", fetch_addr, 10'h201);
    step(OP_RET, 10'h000, 8'h00, 1'b0, 1'b0);
    check("R10 middle", fetch_addr, 10'h101);
    step(OP_RET, 10'h000, 8'h00, 1'b0, 1'b0);
    check("R11 empty pop", fetch_addr, 10'h101);
    step(OP_RET, 10'h000, 8'h00, 1'b0, 1'b0);
    check("R11 empty pop again", fetch_addr, 10'h101);
    step(OP_LCALL, 10'h050, 8'h00, 1'b0, 1'b0);
    step(OP_RET, 10'h000, 8'h00, 1'b0, 1'b0);
    check("R11 stack usable after underflow", fetch_addr, 10'h102);
  endtask

  initial begin
    rst_n = 1'b0; step_en = 1'b0; flow_op = OP_SEQ; addr_field = '0;
    alu_result = '0; page_sel = 1'b0; skip_req = 1'b0;
    t_reset();
    t_hold();
    t_seq();
    t_skip();
    t_long();
    t_short_jmp();
    t_short_call();
    t_pcwr();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule